// File: doc/BRIEF.md
# Configurable GPIO Port Controller

A multi-pin general-purpose I/O port in which every pin carries its own configuration word and the port shares one data register. The configuration decides whether a pin drives push-pull or open-drain, whether its driver is on, whether the SPI engine owns the pin, and whether and on which edge it raises an interrupt. Four further bits per pin (input threshold, sink strength, pull-up, low-voltage drive) are held and sent straight to the pad as static controls. They have no effect on any logic in the block.

Pad inputs pass through a two-flop synchronizer and then an edge detector. Pins outside the shared group set sticky per-pin pending flags, which software clears by writing 1. Pins inside the compile-time shared group feed one group interrupt. A two-state machine guards that interrupt: GRP_READY accepts an active edge from any enabled group pin, raises the group flag and moves to GRP_LATCHED. GRP_LATCHED ignores further edges and returns to GRP_READY only once every enabled group pin sits at its inactive level.

Registers are reached over a simple synchronous write, combinational read bus. Address 0 is the data register, 1 the per-pin pending flags, 2 the synchronized pin levels (read only), 3 the group flag (bit 0), and 4+i the configuration word of pin i.

Top module: `gpio_port_ctrl`

## Requirements
- R1: A pin's pending flag (or the group flag) can only be set while configuration bit 0 (interrupt enable) of that pin is 1. With the bit at 0, edges leave all interrupt outputs at 0.
- R2: Configuration bit 1 selects the active edge: 0 means a low-to-high transition, 1 means a high-to-low transition. The other edge sets nothing.
- R3: Edge detection works on the pad level whatever the output configuration is. A pin driving its own output to the active level raises its own interrupt.
- R4: With bit 4 (open-drain) set and bit 7 clear, a data bit of 1 turns the driver off and a data bit of 0 drives low while bit 6 (output enable) is 1.
- R5: With bits 4 and 7 clear, pad_out equals the data bit and pad_oe equals bit 6.
- R6: With bit 7 (SPI use) set, pad_out and pad_oe follow spi_out and spi_oe for that pin. Clearing the bit returns the pin to GPIO control.
- R7: Bits 2, 3, 5 and 8 appear unchanged on pad_ttl, pad_hisink, pad_pullup and pad_3v3 and change neither drive nor interrupts.
- R8: Edges on pins in SHARED_MASK set only the group flag, never their per-pin flag. After one group interrupt, no further one fires until every enabled group pin has returned to its inactive level (low for rising, high for falling).
- R9: After reset, every configuration word, the data register and all flags are 0, so no pin drives and no interrupt is raised.
- R10: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A new edge in the same cycle wins over the clear.
- R11: The synchronized level reads back two clock edges after a pad change, and the resulting flag shows three edges after it.
- R12: The level register reflects the pad even while the pin's own driver is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| pad_in | input | NPINS | Raw pad levels |
| pad_out | output | NPINS | Pad output value |
| pad_oe | output | NPINS | Pad driver enable |
| spi_out | input | NPINS | SPI engine output value per pin |
| spi_oe | input | NPINS | SPI engine driver enable per pin |
| pad_ttl | output | NPINS | Input threshold select |
| pad_hisink | output | NPINS | High sink strength select |
| pad_pullup | output | NPINS | Pull-up enable |
| pad_3v3 | output | NPINS | Low-voltage drive select |
| irq_pin | output | NPINS | Per-pin pending flags |
| irq_shared | output | 1 | Group interrupt flag |

## Verification
Pad drive and the static pad controls come straight from registers, so they change at the clock edge that accepts the write. The bench checks them at the falling edge that follows. A pad change reaches the level register after two rising edges and the flags after three. The bench changes pad inputs at a falling edge and counts that many falling edges before sampling, and it also samples once a cycle early to confirm nothing arrives too soon. Checks on the group state machine wait four cycles after each pad change, so a flag that should stay clear has had time to appear if the design were wrong.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef struct packed {
        logic drv_3v3;
        logic spi_use;
        logic out_en;
        logic pull_up;
        logic open_drain;
        logic hi_sink;
        logic ttl_thr;
        logic irq_fall;
        logic irq_en;
    } pin_cfg_t;

    localparam int CFG_W = $bits(pin_cfg_t);

    localparam int ADDR_DATA  = 0;
    localparam int ADDR_PEND  = 1;
    localparam int ADDR_LEVEL = 2;
    localparam int ADDR_GROUP = 3;
    localparam int ADDR_CFG0  = 4;

    typedef enum logic {
        GRP_READY   = 1'b0,
        GRP_LATCHED = 1'b1
    } grp_state_t;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] lvl,
    output logic [NPINS-1:0] lvl_prev
);
    logic [NPINS-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            lvl      <= '0;
            lvl_prev <= '0;
        end else begin
            meta_q   <= pad_in;
            lvl      <= meta_q;
            lvl_prev <= lvl;
        end
    end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int NPINS = 8
) (
    input  logic [NPINS-1:0] data_bits,
    input  logic [NPINS-1:0] oe_bits,
    input  logic [NPINS-1:0] od_bits,
    input  logic [NPINS-1:0] spi_bits,
    input  logic [NPINS-1:0] spi_out,
    input  logic [NPINS-1:0] spi_oe,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        always_comb begin
            if (spi_bits[i]) begin
                pad_out[i] = spi_out[i];
                pad_oe[i]  = spi_oe[i];
            end else if (od_bits[i]) begin
                pad_out[i] = 1'b0;
                pad_oe[i]  = oe_bits[i] & ~data_bits[i];
            end else begin
                pad_out[i] = data_bits[i];
                pad_oe[i]  = oe_bits[i];
            end
        end
    end
endmodule

// File: rtl/gpio_group_fsm.sv
module gpio_group_fsm
    import gpio_port_pkg::*;
#(
    parameter int               NPINS = 8,
    parameter logic [NPINS-1:0] MASK  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] act_edge,
    input  logic [NPINS-1:0] irq_en,
    input  logic [NPINS-1:0] inactive,
    output logic             fire
);
    grp_state_t       state_q, state_d;
    logic [NPINS-1:0] contrib;
    logic             hit, quiet;

    assign contrib = irq_en & MASK;
    assign hit     = |(act_edge & contrib);
    assign quiet   = &(~contrib | inactive);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GRP_READY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GRP_READY:   if (hit)   state_d = GRP_LATCHED;
            GRP_LATCHED: if (quiet) state_d = GRP_READY;
            default:                state_d = GRP_READY;
        endcase
    end

    always_comb begin
        unique case (state_q)
            GRP_READY:   fire = hit;
            GRP_LATCHED: fire = 1'b0;
            default:     fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int               NPINS       = 8,
    parameter logic [NPINS-1:0] SHARED_MASK = 8'hF0,
    parameter int               DATA_W      = 16,
    parameter int               ADDR_W      = $clog2(NPINS + ADDR_CFG0)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    input  logic [NPINS-1:0]  spi_out,
    input  logic [NPINS-1:0]  spi_oe,
    output logic [NPINS-1:0]  pad_ttl,
    output logic [NPINS-1:0]  pad_hisink,
    output logic [NPINS-1:0]  pad_pullup,
    output logic [NPINS-1:0]  pad_3v3,
    output logic [NPINS-1:0]  irq_pin,
    output logic              irq_shared
);
    pin_cfg_t         cfg_q [NPINS];
    logic [NPINS-1:0] data_q, pend_q;
    logic             grp_q;

    logic [NPINS-1:0] en_v, fall_v, od_v, oe_v, spi_v;
    logic [NPINS-1:0] lvl, lvl_prev, act_edge, inactive;
    logic [NPINS-1:0] pend_set, w1c;
    logic             grp_fire, grp_clr;

    for (genvar i = 0; i < NPINS; i++) begin : g_fields
        assign en_v[i]       = cfg_q[i].irq_en;
        assign fall_v[i]     = cfg_q[i].irq_fall;
        assign od_v[i]       = cfg_q[i].open_drain;
        assign oe_v[i]       = cfg_q[i].out_en;
        assign spi_v[i]      = cfg_q[i].spi_use;
        assign pad_ttl[i]    = cfg_q[i].ttl_thr;
        assign pad_hisink[i] = cfg_q[i].hi_sink;
        assign pad_pullup[i] = cfg_q[i].pull_up;
        assign pad_3v3[i]    = cfg_q[i].drv_3v3;
    end

    gpio_in_sync #(.NPINS(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .lvl(lvl), .lvl_prev(lvl_prev)
    );

    gpio_pad_mux #(.NPINS(NPINS)) u_mux (
        .data_bits(data_q), .oe_bits(oe_v), .od_bits(od_v), .spi_bits(spi_v),
        .spi_out(spi_out), .spi_oe(spi_oe), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    always_comb begin
        for (int i = 0; i < NPINS; i++) begin
            act_edge[i] = fall_v[i] ? (lvl_prev[i] & ~lvl[i]) : (~lvl_prev[i] & lvl[i]);
            inactive[i] = (lvl[i] == fall_v[i]);
        end
    end

    gpio_group_fsm #(.NPINS(NPINS), .MASK(SHARED_MASK)) u_grp (
        .clk(clk), .rst_n(rst_n), .act_edge(act_edge), .irq_en(en_v),
        .inactive(inactive), .fire(grp_fire)
    );

    assign pend_set = act_edge & en_v & ~SHARED_MASK;
    assign w1c      = (bus_we && bus_addr == ADDR_W'(ADDR_PEND)) ? bus_wdata[NPINS-1:0] : '0;
    assign grp_clr  = bus_we && bus_addr == ADDR_W'(ADDR_GROUP) && bus_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            pend_q <= '0;
            grp_q  <= 1'b0;
            for (int i = 0; i < NPINS; i++) cfg_q[i] <= '0;
        end else begin
            pend_q <= (pend_q & ~w1c) | pend_set;
            grp_q  <= (grp_q & ~grp_clr) | grp_fire;
            if (bus_we && bus_addr == ADDR_W'(ADDR_DATA)) data_q <= bus_wdata[NPINS-1:0];
            for (int i = 0; i < NPINS; i++) begin
                if (bus_we && bus_addr == ADDR_W'(ADDR_CFG0 + i))
                    cfg_q[i] <= pin_cfg_t'(bus_wdata[CFG_W-1:0]);
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(ADDR_DATA))  bus_rdata[NPINS-1:0] = data_q;
        if (bus_addr == ADDR_W'(ADDR_PEND))  bus_rdata[NPINS-1:0] = pend_q;
        if (bus_addr == ADDR_W'(ADDR_LEVEL)) bus_rdata[NPINS-1:0] = lvl;
        if (bus_addr == ADDR_W'(ADDR_GROUP)) bus_rdata[0]         = grp_q;
        for (int i = 0; i < NPINS; i++) begin
            if (bus_addr == ADDR_W'(ADDR_CFG0 + i)) bus_rdata[CFG_W-1:0] = cfg_q[i];
        end
    end

    assign irq_pin    = pend_q;
    assign irq_shared = grp_q;
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
    parameter int               NPINS       = 8,
    parameter logic [NPINS-1:0] SHARED_MASK = 8'hF0
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe,
    input logic [NPINS-1:0] spi_out,
    input logic [NPINS-1:0] spi_oe,
    input logic [NPINS-1:0] od_v,
    input logic [NPINS-1:0] spi_v,
    input logic [NPINS-1:0] en_v,
    input logic [NPINS-1:0] fall_v,
    input logic [NPINS-1:0] lvl,
    input logic [NPINS-1:0] irq_pin,
    input logic [NPINS-1:0] pend_set,
    input logic [NPINS-1:0] w1c,
    input logic             grp_fire
);
    logic             armed_q;
    logic [NPINS-1:0] grp_pins;
    logic             grp_idle;

    assign grp_pins = en_v & SHARED_MASK;
    assign grp_idle = &(~grp_pins | ~(lvl ^ fall_v));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        armed_q <= 1'b0;
        else if (grp_fire) armed_q <= 1'b1;
        else if (grp_idle) armed_q <= 1'b0;
    end

    assert_od_never_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((od_v & ~spi_v & pad_oe & pad_out) == '0));

    assert_spi_owns_pad_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((spi_v & ((pad_oe ^ spi_oe) | (pad_out ^ spi_out))) == '0));

    assert_masked_no_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_pin & ~$past(irq_pin) & ~$past(en_v)) == '0));

    assert_w1c_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((w1c & ~pend_set) != '0) |=> ((irq_pin & $past(w1c & ~pend_set)) == '0));

    assert_no_refire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        grp_fire |-> !armed_q);
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NPINS(NPINS), .SHARED_MASK(SHARED_MASK)) u_chk (
    .clk(clk), .rst_n(rst_n), .pad_out(pad_out), .pad_oe(pad_oe),
    .spi_out(spi_out), .spi_oe(spi_oe), .od_v(od_v), .spi_v(spi_v),
    .en_v(en_v), .fall_v(fall_v), .lvl(lvl), .irq_pin(irq_pin),
    .pend_set(pend_set), .w1c(w1c), .grp_fire(grp_fire)
);

// File: tb/sim_gpio_port_ctrl.sv
module sim_gpio_port_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int DW = 16;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [N-1:0]  pad_in, pad_out, pad_oe, ext_in = '0;
    logic [N-1:0]  spi_out = '0, spi_oe = '0;
    logic [N-1:0]  pad_ttl, pad_hisink, pad_pullup, pad_3v3, irq_pin;
    logic          irq_shared;
    logic [N-1:0]  data_sh = '0;
    int            n_checks = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_in);

    gpio_port_ctrl #(.NPINS(N), .SHARED_MASK(8'hF0), .DATA_W(DW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .spi_out(spi_out), .spi_oe(spi_oe),
        .pad_ttl(pad_ttl), .pad_hisink(pad_hisink), .pad_pullup(pad_pullup),
        .pad_3v3(pad_3v3), .irq_pin(irq_pin), .irq_shared(irq_shared)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic wr(input int addr, input logic [DW-1:0] d);
        bus_we = 1'b1; bus_addr = AW'(addr); bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic rd(input int addr, output logic [DW-1:0] d);
        bus_addr = AW'(addr); #1; d = bus_rdata; bus_addr = '0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_data(input int pin, input logic v);
        data_sh[pin] = v;
        wr(0, DW'(data_sh));
    endtask

    // expected {oe,out} from configuration, data bit and SPI inputs
    function automatic logic [1:0] exp_drive(input logic [8:0] c, input logic d,
                                             input logic so, input logic soe);
        if (c[7])      return {soe, so};
        else if (c[4]) return {c[6] & ~d, 1'b0};
        else           return {c[6], d};
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [DW-1:0] rv;
        void'($urandom(32'd4242));
        cyc(3); rst_n = 1'b1; cyc(1);

        // R9 reset state
        chk("R9 pad_oe", 32'(pad_oe), 0);
        chk("R9 irq_pin", 32'(irq_pin), 0);
        chk("R9 irq_shared", 32'(irq_shared), 0);
        rd(4, rv); chk("R9 cfg0", 32'(rv), 0);
        rd(0, rv); chk("R9 data", 32'(rv), 0);

        // R5 push-pull on pin 1
        wr(5, 16'h0040); set_data(1, 1'b1);
        chk("R5 out hi", 32'(pad_out[1]), 1); chk("R5 oe", 32'(pad_oe[1]), 1);
        set_data(1, 1'b0);
        chk("R5 out lo", 32'(pad_out[1]), 0);

        // R4 open drain on pin 2
        wr(6, 16'h0050); set_data(2, 1'b1);
        chk("R4 data1 hiZ", 32'(pad_oe[2]), 0);
        set_data(2, 1'b0);
        chk("R4 data0 oe", 32'(pad_oe[2]), 1); chk("R4 data0 low", 32'(pad_out[2]), 0);

        // R6 SPI takeover on pin 3
        spi_oe[3] = 1'b1; spi_out[3] = 1'b1; wr(7, 16'h0080);
        chk("R6 spi oe", 32'(pad_oe[3]), 1); chk("R6 spi out", 32'(pad_out[3]), 1);
        spi_out[3] = 1'b0; #1;
        chk("R6 spi follows", 32'(pad_out[3]), 0);
        wr(7, 16'h0000);
        chk("R6 gpio back", 32'(pad_oe[3]), 0);
        spi_oe[3] = 1'b0;

        // R7 static pad controls on pin 0
        wr(4, 16'h012C);
        chk("R7 ttl", 32'(pad_ttl[0]), 1); chk("R7 hisink", 32'(pad_hisink[0]), 1);
        chk("R7 pullup", 32'(pad_pullup[0]), 1); chk("R7 3v3", 32'(pad_3v3[0]), 1);
        chk("R7 no drive", 32'(pad_oe[0]), 0);

        // R11 / R12 level readback
        ext_in[0] = 1'b1; cyc(1);
        rd(2, rv); chk("R11 level early", 32'(rv[0]), 0);
        cyc(1); rd(2, rv); chk("R11 level due", 32'(rv[0]), 1);
        wr(5, 16'h0040); set_data(1, 1'b1); cyc(3);
        rd(2, rv); chk("R12 driven level", 32'(rv[1]), 1);
        chk("R7 static no irq", 32'(irq_pin), 0);

        // R2 / R11 polarity and latency on pin 0
        wr(4, 16'h0001); ext_in[0] = 1'b0; cyc(4); wr(1, 16'h00FF);
        chk("R2 fall ignored on rising", 32'(irq_pin[0]), 0);
        ext_in[0] = 1'b1; cyc(2);
        chk("R11 flag early", 32'(irq_pin[0]), 0);
        cyc(1); chk("R11 flag due", 32'(irq_pin[0]), 1);
        wr(1, 16'h0000); chk("R10 write0 keeps", 32'(irq_pin[0]), 1);
        wr(1, 16'h0001); chk("R10 write1 clears", 32'(irq_pin[0]), 0);
        wr(4, 16'h0003); ext_in[0] = 1'b0; cyc(3);
        chk("R2 falling", 32'(irq_pin[0]), 1);
        wr(1, 16'h00FF); wr(4, 16'h0000);
        ext_in[0] = 1'b1; cyc(4); ext_in[0] = 1'b0; cyc(4);
        chk("R1 disabled", 32'(irq_pin), 0);

        // R3 self-trigger on pin 1 driven push-pull
        set_data(1, 1'b0); wr(5, 16'h0041); cyc(4); wr(1, 16'h00FF);
        set_data(1, 1'b1); cyc(3);
        chk("R3 self trigger", 32'(irq_pin[1]), 1);
        wr(5, 16'h0000); wr(1, 16'h00FF);

        // R8 shared group on pins 4,5
        wr(8, 16'h0001); wr(9, 16'h0001); cyc(4);
        ext_in[4] = 1'b1; cyc(3);
        chk("R8 group fires", 32'(irq_shared), 1);
        chk("R8 no per-pin flag", 32'(irq_pin[4]), 0);
        wr(3, 16'h0001); chk("R10 group clear", 32'(irq_shared), 0);
        ext_in[5] = 1'b1; cyc(4);
        chk("R8 blocked while active", 32'(irq_shared), 0);
        ext_in[4] = 1'b0; cyc(4); ext_in[4] = 1'b1; cyc(4);
        chk("R8 still blocked", 32'(irq_shared), 0);
        ext_in[4] = 1'b0; ext_in[5] = 1'b0; cyc(4);
        ext_in[5] = 1'b1; cyc(4);
        chk("R8 rearmed", 32'(irq_shared), 1);
        wr(8, 16'h0000); wr(9, 16'h0000); wr(3, 16'h0001);
        ext_in[5] = 1'b0;

        // random interrupt patterns on non-shared pins (R1, R2)
        for (int k = 0; k < 40; k++) begin
            int p; logic f, tg, en;
            p = int'($urandom % 4); f = 1'($urandom); tg = 1'($urandom); en = 1'($urandom);
            for (int q = 0; q < 4; q++) wr(4 + q, 16'h0000);
            ext_in[p] = f; cyc(4); wr(1, 16'h00FF);
            wr(4 + p, DW'({f, en}));
            if (tg) ext_in[p] = ~f;
            cyc(3);
            chk(en ? "R2 random edge" : "R1 random masked", 32'(irq_pin[p]), 32'(tg & en));
        end
        for (int q = 0; q < 4; q++) wr(4 + q, 16'h0000);

        // random drive patterns (R4, R5, R6, R7)
        for (int k = 0; k < 40; k++) begin
            int p; logic [8:0] c; logic [1:0] e;
            p = int'($urandom % N); c = 9'($urandom) & 9'h1FE;
            spi_out[p] = 1'($urandom); spi_oe[p] = 1'($urandom);
            wr(4 + p, DW'(c)); set_data(p, 1'($urandom));
            e = exp_drive(c, data_sh[p], spi_out[p], spi_oe[p]);
            chk("R5 random drive", 32'({pad_oe[p], pad_out[p]}), 32'(e));
            chk("R7 random static", 32'({pad_3v3[p], pad_pullup[p], pad_hisink[p], pad_ttl[p]}),
                32'({c[8], c[5], c[3], c[2]}));
            wr(4 + p, 16'h0000);
        end

        finish_run();
    end
endmodule